// File: doc/BRIEF.md
# Indexed Periodic Timer Bank

A bank of independently programmed down-counting timers, each producing a sticky pending interrupt bit for an interrupt hub. Software reaches every timer through one register port. A function code selects the register kind and a 5-bit index selects the timer. Each timer has a reload period and a live counter, and software can read and overwrite both. While its period is nonzero a timer counts down once per clock. On expiry it reloads from the period and raises its pending bit. That bit holds until software writes the acknowledge code for that timer.

The register port is plain control, with no valid/ready handshake. A write strobe acts at the next rising clock edge and never stalls. Read data is combinational from the current function code and index. The pending bits are level outputs, with no handshake or back-pressure, and the hub samples them whenever it needs to.

Top module: `tmr_bank`

## Requirements
- R1: While `rst_n` is low, and after its release, every period, every count and every pending bit is zero.
- R2: A write with function code 1 sets the indexed timer's period and also loads its count with the written value. A read with code 1 returns the period.
- R3: A write with function code 2 replaces the indexed timer's count. A read with code 2 returns the live count.
- R4: A timer whose period is nonzero and whose count is above 1 decrements its count by one on each clock edge that carries no write to that timer.
- R5: A timer whose period is nonzero and whose count is 1 or 0 expires. On that edge its count reloads from the period and its pending bit (bit i of `pend_o` for timer i) becomes 1.
- R6: A timer whose period is zero holds its count and never sets its pending bit.
- R7: A pending bit stays 1 through further expiries until a write with function code 3 to that index clears it.
- R8: When an acknowledge and an expiry fall on the same edge, the pending bit stays 1.
- R9: Reads with function code 3, reads with any code other than 1 or 2, and reads with an index at or above the timer count all return zero. Writes to an index at or above the timer count change no timer.
- R10: A period or count write takes priority over counting on that edge, so the written value is what the count shows afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func_sel | input | 5 | Function code: 1 period, 2 count, 3 acknowledge |
| tmr_idx | input | 5 | Timer index |
| wr_data | input | DW | Write data |
| wr_en | input | 1 | Write strobe |
| rd_data | output | DW | Combinational read data |
| pend_o | output | max(NUM_TMR,1) | Pending interrupt bit per timer |

## Verification
The assertions check several properties on every cycle in each timer slot. Counting proceeds by one step. Expiry reloads the count and raises the pending bit. A stopped timer stays quiet. A pending bit survives until it is acknowledged, including when the acknowledge races an expiry. Only the bench scenarios can show the register port's observable behaviour. This covers read decoding, zero returns for unused codes and out-of-range indices, and write priority. It also covers the interaction of many timers running at once under random period, count and acknowledge traffic, compared against a bench reference model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [4:0] {
    FN_PERIOD = 5'd1,
    FN_COUNT  = 5'd2,
    FN_ACK    = 5'd3
  } tmr_func_e;
endpackage

// File: rtl/tmr_slot.sv
module tmr_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          per_wr,
  input  logic          cnt_wr,
  input  logic          ack,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] per_q,
  output logic [DW-1:0] cnt_q,
  output logic          pend_q
);
  logic running, expire;

  assign running = (per_q != '0);
  assign expire  = running && !per_wr && !cnt_wr && (cnt_q <= DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (per_wr) begin
        per_q <= wdata;
        cnt_q <= wdata;
      end else if (cnt_wr) begin
        cnt_q <= wdata;
      end else if (expire) begin
        cnt_q <= per_q;
      end else if (running) begin
        cnt_q <= cnt_q - DW'(1);
      end
      pend_q <= (pend_q && !ack) || expire;
    end
  end

  // R4: one step down per clock while running
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_wr && !cnt_wr && per_q != '0 && cnt_q > DW'(1)) |=> (cnt_q == $past(cnt_q) - DW'(1)));

  // R5: expiry reloads and raises pending
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_wr && !cnt_wr && per_q != '0 && cnt_q <= DW'(1)) |=> (cnt_q == $past(per_q) && pend_q));

  // R6: stopped timer stays quiet
  a_r6_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_wr && per_q == '0 && !pend_q) |=> !pend_q);

  // R7: pending is sticky without acknowledge
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack) |=> pend_q);

  // R8: acknowledge racing an expiry leaves pending set
  a_r8_race: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !per_wr && !cnt_wr && per_q != '0 && cnt_q <= DW'(1)) |=> pend_q);
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux #(
  parameter int NUM_TMR = 8,
  parameter int DW      = 32,
  localparam int PW     = (NUM_TMR == 0) ? 1 : NUM_TMR
) (
  input  logic [4:0]            func_sel,
  input  logic [4:0]            tmr_idx,
  input  logic [PW-1:0][DW-1:0] per_v,
  input  logic [PW-1:0][DW-1:0] cnt_v,
  output logic [DW-1:0]         rd_data
);
  import tmr_pkg::*;

  generate
    if (NUM_TMR == 0) begin : g_none
      assign rd_data = '0;
    end else begin : g_mux
      logic in_range;
      assign in_range = ({1'b0, tmr_idx} < 6'(NUM_TMR));
      always_comb begin
        rd_data = '0;
        if (in_range) begin
          if (func_sel == FN_PERIOD)     rd_data = per_v[tmr_idx];
          else if (func_sel == FN_COUNT) rd_data = cnt_v[tmr_idx];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int NUM_TMR = 8,
  parameter int DW      = 32,
  localparam int PW     = (NUM_TMR == 0) ? 1 : NUM_TMR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    func_sel,
  input  logic [4:0]    tmr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_en,
  output logic [DW-1:0] rd_data,
  output logic [PW-1:0] pend_o
);
  import tmr_pkg::*;

  logic [PW-1:0][DW-1:0] per_v, cnt_v;

  generate
    if (NUM_TMR == 0) begin : g_empty
      assign per_v  = '0;
      assign cnt_v  = '0;
      assign pend_o = '0;
    end else begin : g_bank
      for (genvar i = 0; i < NUM_TMR; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (tmr_idx == 5'(i));
        tmr_slot #(.DW(DW)) u_slot (
          .clk    (clk),
          .rst_n  (rst_n),
          .per_wr (hit && func_sel == FN_PERIOD),
          .cnt_wr (hit && func_sel == FN_COUNT),
          .ack    (hit && func_sel == FN_ACK),
          .wdata  (wr_data),
          .per_q  (per_v[i]),
          .cnt_q  (cnt_v[i]),
          .pend_q (pend_o[i])
        );
      end
    end
  endgenerate

  tmr_rdmux #(.NUM_TMR(NUM_TMR), .DW(DW)) u_rdmux (
    .func_sel (func_sel),
    .tmr_idx  (tmr_idx),
    .per_v    (per_v),
    .cnt_v    (cnt_v),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int N  = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] func_sel = '0, tmr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic [N-1:0] pend_o;

  int tests = 0, fails = 0;
  logic [DW-1:0] mper [N];
  logic [DW-1:0] mcnt [N];
  logic [N-1:0]  mpend;

  always #5ns clk = ~clk;

  tmr_bank #(.NUM_TMR(N), .DW(DW)) u_tmr_bank (
    .clk(clk), .rst_n(rst_n), .func_sel(func_sel), .tmr_idx(tmr_idx),
    .wr_data(wr_data), .wr_en(wr_en), .rd_data(rd_data), .pend_o(pend_o)
  );

  function automatic logic [DW-1:0] exp_read(input logic [4:0] f, input logic [4:0] i);
    if (i >= 5'(N)) return '0;
    if (f == 5'd1) return mper[i];
    if (f == 5'd2) return mcnt[i];
    return '0;
  endfunction

  function automatic void model_reset();
    for (int t = 0; t < N; t++) begin mper[t] = '0; mcnt[t] = '0; end
    mpend = '0;
  endfunction

  function automatic void model_step(input logic [4:0] f, input logic [4:0] i,
                                     input logic [DW-1:0] d, input logic w);
    for (int t = 0; t < N; t++) begin
      logic pw, cw, ak, ex;
      pw = w && f == 5'd1 && i == 5'(t);
      cw = w && f == 5'd2 && i == 5'(t);
      ak = w && f == 5'd3 && i == 5'(t);
      ex = 1'b0;
      if (pw) begin mper[t] = d; mcnt[t] = d; end
      else if (cw) mcnt[t] = d;
      else if (mper[t] != '0) begin
        if (mcnt[t] <= 1) begin mcnt[t] = mper[t]; ex = 1'b1; end
        else mcnt[t] = mcnt[t] - 1;
      end
      mpend[t] = (mpend[t] && !ak) || ex;
    end
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, check before the edge, step model at the edge
  task automatic cyc(input logic [4:0] f, input logic [4:0] i, input logic [DW-1:0] d,
                     input logic w, input string tag);
    @(negedge clk);
    func_sel = f; tmr_idx = i; wr_data = d; wr_en = w;
    #1ns;
    check({tag, " read"}, rd_data, exp_read(f, i));
    check({tag, " pend"}, DW'(pend_o), DW'(mpend));
    @(posedge clk);
    if (rst_n) model_step(f, i, d, w);
    else model_reset();
  endtask

  initial begin
    #2ms;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    model_reset();
    // R1: reset state
    rst_n = 1'b0;
    cyc(5'd1, 5'd0, 32'd9, 1'b1, "R1");
    cyc(5'd2, 5'd3, 32'd0, 1'b0, "R1");
    rst_n = 1'b1;
    for (int t = 0; t < N; t++) cyc(5'd1, 5'(t), '0, 1'b0, "R1");
    for (int t = 0; t < N; t++) cyc(5'd2, 5'(t), '0, 1'b0, "R1");

    // R2, R4, R5: period 5 on timer 0, watch count fall and reload
    cyc(5'd1, 5'd0, 32'd5, 1'b1, "R2");
    for (int k = 0; k < 8; k++) cyc(5'd2, 5'd0, '0, 1'b0, "R4 R5");
    check("R5 pend0", DW'(pend_o[0]), 32'd1);
    // R7: stays pending over more expiries, then acknowledge
    for (int k = 0; k < 6; k++) cyc(5'd1, 5'd0, '0, 1'b0, "R7");
    cyc(5'd3, 5'd0, '0, 1'b1, "R7");
    cyc(5'd3, 5'd0, '0, 1'b0, "R9");

    // R6: zero period holds count, never pends
    cyc(5'd2, 5'd1, 32'd7, 1'b1, "R6");
    for (int k = 0; k < 10; k++) cyc(5'd2, 5'd1, '0, 1'b0, "R6");
    check("R6 pend1", DW'(pend_o[1]), 32'd0);

    // R8: acknowledge on the expiry edge
    cyc(5'd1, 5'd2, 32'd3, 1'b1, "R8");
    cyc(5'd2, 5'd2, '0, 1'b0, "R8");
    cyc(5'd2, 5'd2, '0, 1'b0, "R8");
    cyc(5'd3, 5'd2, '0, 1'b1, "R8");
    cyc(5'd0, 5'd0, '0, 1'b0, "R8");
    check("R8 pend2", DW'(pend_o[2]), 32'd1);

    // R10: count write wins over running countdown
    cyc(5'd1, 5'd3, 32'd50, 1'b1, "R10");
    cyc(5'd2, 5'd3, 32'd20, 1'b1, "R10");
    cyc(5'd2, 5'd3, '0, 1'b0, "R10");
    check("R10 cnt3", rd_data, 32'd20);

    // R9: out-of-range index and unused codes
    cyc(5'd1, 5'd9, 32'd4, 1'b1, "R9");
    cyc(5'd1, 5'd9, '0, 1'b0, "R9");
    cyc(5'd7, 5'd0, '0, 1'b0, "R9");
    cyc(5'd0, 5'd0, '0, 1'b0, "R9");

    // random traffic, R3 and everything else against the model
    for (int k = 0; k < 4000; k++) begin
      logic [4:0] f, i;
      logic [DW-1:0] d;
      logic w;
      f = 5'($urandom_range(0, 4));
      i = 5'($urandom_range(0, N + 1));
      d = ($urandom_range(0, 3) == 0) ? '0 : DW'($urandom_range(1, 12));
      w = ($urandom_range(0, 5) == 0);
      cyc(f, i, d, w, "R3 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule